// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block brings up a downstream programmable device that loads its configuration through a slave-serial pin set. A single start pulse, together with a total byte count, makes it switch the target's power on and wait for the supply to settle. It then pulses the active-low program pin and waits for the target's init line to report that it can take data. Image bytes come in on a valid/ready stream, and each is sent most significant bit first as a data level followed by one configuration clock pulse.

When the last byte has gone out, the loader keeps pulsing the configuration clock until the target raises its done line. Both waits have an upper bound. A busy output covers the whole sequence. When it drops, exactly one of three sticky status flags is set: success, init timeout or done timeout. The flag holds until the next start. An error input from the byte source cuts the data phase short, and the loader then moves straight on to the done phase.

Top module: `serialCfgLoader`

## Requirements
- R1: After reset, `powerEn`, `cclk`, `dout` and `busy` are low and `progN` is high. Whenever `busy` is low, `progN` is high and `cclk` and `dout` are low.
- R2: A `start` pulse in idle sets `powerEn`, which then stays high, and raises `busy`. `progN` stays high for exactly `SETTLE_CYCLES` clock cycles and is then driven low for exactly `HOLD_CYCLES` cycles.
- R3: After `progN` is released, the synchronised init input is polled once per cycle for at most `INIT_POLLS` cycles. If it never reads high, `busy` falls exactly `SETTLE_CYCLES+HOLD_CYCLES+INIT_POLLS` cycles after start, `initTimeout` is set and no `cclk` pulse is issued.
- R4: Each byte is sent bit 7 first, down to bit 0. `dout` holds still on every rising `cclk` edge. Each high phase of `cclk` lasts `phaseLen` cycles, and a `phaseLen` of 0 is treated as 1.
- R5: `inReady` is high only in the data phase, only with the shifter empty and bytes still owed. When it is high, `cclk` and `dout` are low.
- R6: Exactly `byteCount` bytes are accepted, and the serial stream carries them in order.
- R7: `inError` ends the data phase. A byte offered in the same cycle as `inError` is not accepted, and the done phase follows.
- R8: After the data, `cclk` pulses with `dout` low continue while done is low. Once done is seen high, `cfgOk` is set and `busy` falls.
- R9: If done stays low, exactly `DONE_PULSES` extra pulses are issued and `doneTimeout` is set.
- R10: When `busy` falls, exactly one of `cfgOk`, `initTimeout` and `doneTimeout` is high. The flags hold until the next `start`, which clears them.
- R11: A transfer with `byteCount` of 0 sends no data bits and goes straight to the done phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin configuration |
| byteCount | input | COUNT_W | Number of image bytes, sampled at start |
| phaseLen | input | PHASE_W | Length of each clock phase in system cycles (0 acts as 1) |
| inByte | input | 8 | Image byte from the source |
| inValid | input | 1 | Source has a byte |
| inError | input | 1 | Source failure, ends the data phase |
| inReady | output | 1 | Loader takes the byte this cycle |
| cfgInit | input | 1 | Target ready-for-data line (asynchronous) |
| cfgDone | input | 1 | Target configuration-complete line (asynchronous) |
| powerEn | output | 1 | Target supply enable |
| progN | output | 1 | Active-low program pin |
| cclk | output | 1 | Configuration clock |
| dout | output | 1 | Configuration data |
| busy | output | 1 | Sequence in progress |
| cfgOk | output | 1 | Sticky success flag |
| initTimeout | output | 1 | Sticky init-wait timeout flag |
| doneTimeout | output | 1 | Sticky done-wait timeout flag |

## Verification
Two events can land in the same cycle: the source raising `inError`, and the handshake that would accept the next byte. The bench raises the error exactly when a byte is on offer and the shifter has just emptied. It then confirms that the byte count stops at the number taken before the error and that the done phase still follows. A second overlap sits at the end of the data. Done can rise during the last data bits or during a flush pulse, so the bench places the target's done rise a few pulses after the data and checks that the flush pulse count falls inside a two-pulse window above that point.

// File: rtl/serialCfgLoaderPkg.sv
package serialCfgLoaderPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PROG,
    ST_WAITINIT,
    ST_DATA,
    ST_FLUSH
  } loaderState_t;

  // strobes from the control to the bit engine
  typedef struct packed {
    logic loadByte;   // take inByte, send 8 bits
    logic loadPulse;  // send a single low data bit (one clock pulse)
  } shiftCmd_t;

endpackage

// File: rtl/serialCfgShifter.sv
module serialCfgShifter
  import serialCfgLoaderPkg::*;
#(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  shiftCmd_t          cmd,
  input  logic [7:0]         inByte,
  input  logic [PHASE_W-1:0] phaseLen,
  input  logic               cfgInit,
  input  logic               cfgDone,
  output logic               initSync,
  output logic               doneSync,
  output logic               shiftEmpty,
  output logic               cclk,
  output logic               dout
);

  logic [7:0]         shReg;
  logic [3:0]         bitsLeft;
  logic [PHASE_W-1:0] phaseCnt;
  logic [PHASE_W-1:0] effPhase;
  logic [1:0]         initQ;
  logic [1:0]         doneQ;

  assign effPhase   = (phaseLen == '0) ? PHASE_W'(1) : phaseLen;
  assign shiftEmpty = (bitsLeft == 4'd0);
  assign initSync   = initQ[1];
  assign doneSync   = doneQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ <= '0;
      doneQ <= '0;
    end else begin
      initQ <= {initQ[0], cfgInit};
      doneQ <= {doneQ[0], cfgDone};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
      phaseCnt <= '0;
      cclk     <= 1'b0;
      dout     <= 1'b0;
    end else if (cmd.loadByte) begin
      shReg    <= inByte;
      bitsLeft <= 4'd8;
      phaseCnt <= effPhase - PHASE_W'(1);
      cclk     <= 1'b0;
      dout     <= inByte[7];
    end else if (cmd.loadPulse) begin
      shReg    <= '0;
      bitsLeft <= 4'd1;
      phaseCnt <= effPhase - PHASE_W'(1);
      cclk     <= 1'b0;
      dout     <= 1'b0;
    end else if (bitsLeft != 4'd0) begin
      if (phaseCnt != '0) begin
        phaseCnt <= phaseCnt - PHASE_W'(1);
      end else if (!cclk) begin
        cclk     <= 1'b1;
        phaseCnt <= effPhase - PHASE_W'(1);
      end else begin
        cclk     <= 1'b0;
        phaseCnt <= effPhase - PHASE_W'(1);
        bitsLeft <= bitsLeft - 4'd1;
        shReg    <= {shReg[6:0], 1'b0};
        dout     <= (bitsLeft > 4'd1) ? shReg[6] : 1'b0;
      end
    end
  end

  // data must already sit on the pin when the clock rises
  assert_dout_setup_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cclk) |-> $stable(dout));

endmodule

// File: rtl/serialCfgCtrl.sv
module serialCfgCtrl
  import serialCfgLoaderPkg::*;
#(
  parameter int COUNT_W       = 16,
  parameter int SETTLE_CYCLES = 5000000,
  parameter int HOLD_CYCLES   = 5000000,
  parameter int INIT_POLLS    = 100000,
  parameter int DONE_PULSES   = 100000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COUNT_W-1:0] byteCount,
  input  logic               inValid,
  input  logic               inError,
  output logic               inReady,
  input  logic               initSync,
  input  logic               doneSync,
  input  logic               shiftEmpty,
  output shiftCmd_t          cmd,
  output logic               powerEn,
  output logic               progN,
  output logic               busy,
  output logic               cfgOk,
  output logic               initTimeout,
  output logic               doneTimeout
);

  localparam int MAX_A   = (SETTLE_CYCLES > HOLD_CYCLES) ? SETTLE_CYCLES : HOLD_CYCLES;
  localparam int MAX_B   = (INIT_POLLS > DONE_PULSES) ? INIT_POLLS : DONE_PULSES;
  localparam int MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_ALL + 1) + 1;

  loaderState_t       state;
  logic [CNT_W-1:0]   timer;
  logic [COUNT_W-1:0] bytesLeft;
  logic               errSeen;
  logic               accept;

  assign busy    = (state != ST_IDLE);
  assign progN   = (state != ST_PROG);
  assign inReady = (state == ST_DATA) && shiftEmpty && (bytesLeft != '0)
                   && !errSeen && !inError;
  assign accept  = inReady && inValid;

  always_comb begin
    cmd           = '0;
    cmd.loadByte  = accept;
    cmd.loadPulse = (state == ST_FLUSH) && shiftEmpty && !doneSync
                    && (timer != CNT_W'(DONE_PULSES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      timer       <= '0;
      bytesLeft   <= '0;
      errSeen     <= 1'b0;
      powerEn     <= 1'b0;
      cfgOk       <= 1'b0;
      initTimeout <= 1'b0;
      doneTimeout <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state       <= ST_SETTLE;
          timer       <= '0;
          bytesLeft   <= byteCount;
          errSeen     <= 1'b0;
          powerEn     <= 1'b1;
          cfgOk       <= 1'b0;
          initTimeout <= 1'b0;
          doneTimeout <= 1'b0;
        end
        ST_SETTLE: begin
          if (timer == CNT_W'(SETTLE_CYCLES - 1)) begin
            state <= ST_PROG;
            timer <= '0;
          end else timer <= timer + CNT_W'(1);
        end
        ST_PROG: begin
          if (timer == CNT_W'(HOLD_CYCLES - 1)) begin
            state <= ST_WAITINIT;
            timer <= '0;
          end else timer <= timer + CNT_W'(1);
        end
        ST_WAITINIT: begin
          if (initSync) begin
            state <= ST_DATA;
            timer <= '0;
          end else if (timer == CNT_W'(INIT_POLLS - 1)) begin
            state       <= ST_IDLE;
            initTimeout <= 1'b1;
          end else timer <= timer + CNT_W'(1);
        end
        ST_DATA: begin
          if (inError) errSeen <= 1'b1;
          if (accept) begin
            bytesLeft <= bytesLeft - COUNT_W'(1);
          end else if (shiftEmpty && (bytesLeft == '0 || errSeen)) begin
            state <= ST_FLUSH;
            timer <= '0;
          end
        end
        ST_FLUSH: begin
          if (shiftEmpty) begin
            if (doneSync) begin
              state <= ST_IDLE;
              cfgOk <= 1'b1;
            end else if (timer == CNT_W'(DONE_PULSES)) begin
              state       <= ST_IDLE;
              doneTimeout <= 1'b1;
            end else timer <= timer + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_one_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($countones({cfgOk, initTimeout, doneTimeout}) == 1));

  assert_prog_powered_R2: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> powerEn);

endmodule

// File: rtl/serialCfgLoader.sv
module serialCfgLoader
  import serialCfgLoaderPkg::*;
#(
  parameter int COUNT_W       = 16,
  parameter int PHASE_W       = 8,
  parameter int SETTLE_CYCLES = 5000000,
  parameter int HOLD_CYCLES   = 5000000,
  parameter int INIT_POLLS    = 100000,
  parameter int DONE_PULSES   = 100000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COUNT_W-1:0] byteCount,
  input  logic [PHASE_W-1:0] phaseLen,
  input  logic [7:0]         inByte,
  input  logic               inValid,
  input  logic               inError,
  output logic               inReady,
  input  logic               cfgInit,
  input  logic               cfgDone,
  output logic               powerEn,
  output logic               progN,
  output logic               cclk,
  output logic               dout,
  output logic               busy,
  output logic               cfgOk,
  output logic               initTimeout,
  output logic               doneTimeout
);

  shiftCmd_t cmd;
  logic      initSync;
  logic      doneSync;
  logic      shiftEmpty;

  serialCfgCtrl #(
    .COUNT_W(COUNT_W), .SETTLE_CYCLES(SETTLE_CYCLES), .HOLD_CYCLES(HOLD_CYCLES),
    .INIT_POLLS(INIT_POLLS), .DONE_PULSES(DONE_PULSES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .inValid(inValid), .inError(inError), .inReady(inReady),
    .initSync(initSync), .doneSync(doneSync), .shiftEmpty(shiftEmpty),
    .cmd(cmd), .powerEn(powerEn), .progN(progN), .busy(busy),
    .cfgOk(cfgOk), .initTimeout(initTimeout), .doneTimeout(doneTimeout)
  );

  serialCfgShifter #(.PHASE_W(PHASE_W)) uShift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inByte(inByte), .phaseLen(phaseLen),
    .cfgInit(cfgInit), .cfgDone(cfgDone), .initSync(initSync), .doneSync(doneSync),
    .shiftEmpty(shiftEmpty), .cclk(cclk), .dout(dout)
  );

  assert_ready_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!cclk && !dout));

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (progN && !cclk && !dout));

endmodule

// File: tb/sim_serialCfgLoader.sv
`timescale 1ns/1ps
module sim_serialCfgLoader;

  localparam int SETTLE = 20;
  localparam int HOLD   = 10;
  localparam int POLLS  = 40;
  localparam int PULSES = 30;

  logic clk = 0, rstN = 0, start = 0;
  logic [15:0] byteCount = 0;
  logic [7:0]  phaseLen = 1, inByte = 0;
  logic inValid = 0, inError = 0, cfgInit = 0, cfgDone = 0;
  logic inReady, powerEn, progN, cclk, dout, busy, cfgOk, initTimeout, doneTimeout;

  serialCfgLoader #(.COUNT_W(16), .PHASE_W(8), .SETTLE_CYCLES(SETTLE),
    .HOLD_CYCLES(HOLD), .INIT_POLLS(POLLS), .DONE_PULSES(PULSES)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount), .phaseLen(phaseLen),
    .inByte(inByte), .inValid(inValid), .inError(inError), .inReady(inReady),
    .cfgInit(cfgInit), .cfgDone(cfgDone), .powerEn(powerEn), .progN(progN),
    .cclk(cclk), .dout(dout), .busy(busy), .cfgOk(cfgOk),
    .initTimeout(initTimeout), .doneTimeout(doneTimeout));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] txBytes [16];
  logic [7:0] rxBytes [16];
  int nBytes, errAfter, expAcc, acc, rises, doneExtra;
  int settleCnt, holdCnt, busyCnt, hiRun, hiMin, hiMax;
  bit initEn, doneEn, seenProg, take;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int effPhase(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // capture serial bits on the target side
  always @(posedge cclk) begin
    if (rises < 128) rxBytes[rises/8] = {rxBytes[rises/8][6:0], dout};
    rises++;
  end

  // byte source
  always begin
    @(negedge clk);
    take = inValid && inReady;
    @(posedge clk);
    #1;
    if (take) begin
      acc++;
      if (errAfter >= 0 && acc == errAfter) inError = 1;
      else if (acc < nBytes) inByte = txBytes[acc];
      else inValid = 0;
    end
  end

  // target model and pin monitors
  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (busy && progN && !seenProg) settleCnt++;
    if (!progN) begin holdCnt++; seenProg = 1; end
    cfgInit = initEn && seenProg && progN;
    cfgDone = doneEn && (acc == expAcc) && (rises >= 8*expAcc + doneExtra);
    if (cclk) hiRun++;
    else if (hiRun != 0) begin
      if (hiRun < hiMin) hiMin = hiRun;
      if (hiRun > hiMax) hiMax = hiRun;
      hiRun = 0;
    end
  end

  task automatic runOne(input int n, input int p, input bit iEn, input bit dEn,
                        input int extra, input int eAfter);
    @(posedge clk); #1;
    for (int i = 0; i < 16; i++) begin txBytes[i] = 8'($urandom); rxBytes[i] = 0; end
    nBytes = n; errAfter = eAfter; expAcc = (eAfter >= 0) ? eAfter : n;
    acc = 0; rises = 0; doneExtra = extra; initEn = iEn; doneEn = dEn;
    settleCnt = 0; holdCnt = 0; busyCnt = 0; hiRun = 0; hiMin = 1000; hiMax = 0;
    seenProg = 0; inError = 0;
    phaseLen = 8'(p); byteCount = 16'(n);
    inByte = txBytes[0]; inValid = (n > 0);
    start = 1;
    @(posedge clk); #1;
    start = 0;
    check(busy && powerEn, "R2 busy/power after start", busy, 1);
    for (int k = 0; k < 20000 && busy; k++) @(posedge clk);
    @(negedge clk);
    inValid = 0; inError = 0;
  endtask

  task automatic checkData(input string tag);
    int bad = 0;
    for (int i = 0; i < expAcc; i++) if (rxBytes[i] != txBytes[i]) bad++;
    check(bad == 0, {tag, " bytes MSB first in order"}, bad, 0);
    check(acc == expAcc, {tag, " bytes accepted"}, acc, expAcc);
  endtask

  initial begin
    void'($urandom(32'd1234));
    errAfter = -1; nBytes = 0; expAcc = 0; acc = 0; rises = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!powerEn && progN && !cclk && !dout && !busy, "R1 reset pins", {powerEn, progN, cclk, dout, busy}, 5'b01000);
    check(!cfgOk && !initTimeout && !doneTimeout && !inReady, "R1 reset flags", {cfgOk, initTimeout, doneTimeout}, 0);
    rstN = 1;

    // normal transfer
    runOne(4, 1, 1, 1, 5, -1);
    checkData("R6");
    check(settleCnt == SETTLE, "R2 settle length", settleCnt, SETTLE);
    check(holdCnt == HOLD, "R2 program low length", holdCnt, HOLD);
    check(cfgOk && !initTimeout && !doneTimeout, "R8 success flag", cfgOk, 1);
    check(rises - 32 >= 5 && rises - 32 <= 7, "R8 flush pulses window", rises - 32, 5);
    check(progN && !cclk && !dout && !busy, "R1 idle pins after run", {progN, cclk, dout}, 3'b100);
    repeat (50) @(negedge clk);
    check(cfgOk && !busy, "R10 success sticky", cfgOk, 1);

    // phase length 0 and 3
    runOne(2, 0, 1, 1, 2, -1);
    check(hiMin == 1 && hiMax == 1, "R4 phaseLen 0 high width", hiMax, 1);
    checkData("R4 p0");
    runOne(3, 3, 1, 1, 2, -1);
    check(hiMin == 3 && hiMax == 3, "R4 phaseLen 3 high width", hiMax, 3);
    checkData("R4 p3");

    // init timeout
    runOne(3, 1, 0, 1, 2, -1);
    check(initTimeout && !cfgOk && !doneTimeout, "R3 init timeout flag", initTimeout, 1);
    check(rises == 0, "R3 no clock pulses", rises, 0);
    check(busyCnt == SETTLE + HOLD + POLLS, "R3 timeout latency", busyCnt, SETTLE + HOLD + POLLS);
    check(acc == 0, "R5 nothing taken before data phase", acc, 0);

    // done timeout
    runOne(2, 2, 1, 0, 0, -1);
    check(doneTimeout && !cfgOk && !initTimeout, "R9 done timeout flag", doneTimeout, 1);
    check(rises - 16 == PULSES, "R9 flush pulse count", rises - 16, PULSES);
    repeat (40) @(negedge clk);
    check(doneTimeout && !busy, "R10 timeout sticky", doneTimeout, 1);

    // error in the middle, byte on offer in the same cycle
    runOne(6, 1, 1, 1, 3, 2);
    checkData("R7");
    check(cfgOk, "R7 done phase follows error", cfgOk, 1);
    check(!doneTimeout, "R10 start cleared old timeout", doneTimeout, 0);

    // zero bytes
    runOne(0, 1, 1, 1, 3, -1);
    check(acc == 0 && cfgOk, "R11 zero bytes ok", acc, 0);
    check(rises >= 3 && rises <= 5, "R11 only flush pulses", rises, 3);

    // random transfers
    for (int r = 0; r < 5; r++) begin
      int n = 1 + int'($urandom_range(0, 9));
      int p = int'($urandom_range(0, 3));
      runOne(n, p, 1, 1, 2 + int'($urandom_range(0, 3)), -1);
      checkData("R6 random");
      check(hiMax == effPhase(p) && hiMin == effPhase(p), "R4 random high width", hiMax, effPhase(p));
      check(cfgOk, "R8 random success", cfgOk, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule